// File: doc/BRIEF.md
# Four-Channel KCS Mailbox Register Block

This block holds the registers behind four Keyboard-Controller-Style IPMI mailbox channels. Each channel has a byte-wide input data register, an output data register and a status register. The management controller reaches every register through a word-addressed read/write bus with a byte data lane. The host reaches a channel through a second port and selects a data port, a command port or a status port. The framing of the host bus is handled outside this block. This block only sees decoded single-cycle host strokes.

Each buffer-full flag is set by an access from one side of the mailbox and cleared by an access from the other side. A host write marks the input buffer full, and the controller's read of that data empties it. A controller write marks the output buffer full, and the host's read of the data port empties it. Interrupt generation has two gates: a channel enable and an input-interrupt enable. The enable for channel 3 is formed from two separate control bits. The controls and registers for channel 4 sit in a separate high address bank.

The parameter `SHARED_IRQ` selects the interrupt output. With it clear, there is one line per channel. With it set, there is a single line that goes high whenever any bit of the pending vector is set. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `kcs_mbx`

## Requirements
- R1: After reset, every register reads 0x00 from both ports and every interrupt output is low.
- R2: The controller reaches the data and status registers at these word addresses:
  - input data: 9, 10, 11 and 69
  - output data: 12, 13 and 14 and 70
  - status: 15, 16 and 17 and 71
  A controller write stores the byte. A controller read of an output data register has no side effect.
- R3: A host write to channel n's data port (`h_port`=0) or command port (`h_port`=1) loads the input data register and sets status bit 1 (input full). A command-port write sets status bit 3 (command/data), and a data-port write clears that bit.
- R4: A controller read of an input data register returns the data and clears status bit 1. If bit 1 was set before the read, the channel's pending interrupt is cleared on the next edge.
- R5: A controller write to an output data register stores the byte and sets status bit 0 (output full). A host read of the data port returns the output byte and clears bit 0.
- R6: Host writes to the status port (`h_port`=2) are discarded. Host reads of the command or status port return the status byte with no side effect. A controller write to a status register replaces the whole byte.
- R7: The control registers sit at words 0, 2, 4 and 64 and store the byte written. The channel enables are:
  - channel 1: word 0 bit 5
  - channel 2: word 0 bit 6
  - channel 3: word 0 bit 7 AND word 4 bit 2
  - channel 4: word 64 bit 0
- R8: The input-interrupt enables for channels 1 to 3 are word 2 bits 1 to 3. The input-interrupt enable for channel 4 is word 64 bit 1. A host data or command write sets the channel's pending bit only when the channel enable and the interrupt enable are both set at that moment. Changing the enables later does not move the pending bit.
- R9: When `SHARED_IRQ`=0, `irq_o[n]` follows pending bit n one edge after the event that sets or clears it. When `SHARED_IRQ`=1, `irq_o[0]` is the OR of all pending bits.
- R10: When a set and a clear of the same flag happen in the same cycle, the set wins. This applies to the input-full flag, the output-full flag and the pending bit. A host input write beats a controller write to the same input data register in the same cycle.
- R11: Controller reads of unmapped word addresses return 0x00, and controller writes to them change nothing. Host accesses to port 3 or to a channel number above `NUM_CH` have the same behaviour.
- R12: Clearing bit 1 through a controller status write leaves the pending bit unchanged. A later controller read of that input register with bit 1 already clear does not lower the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_wr | input | 1 | Controller write strobe |
| c_rd | input | 1 | Controller read strobe (applies its side effects at the edge) |
| c_addr | input | ADDR_W | Controller word address |
| c_wdata | input | 8 | Controller write data |
| c_rdata | output | 8 | Controller read data (combinational from `c_addr`) |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_chan | input | 2 | Host channel select (0 selects channel 1) |
| h_port | input | 2 | Host port select: 0 data, 1 command, 2 status, 3 none |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data |
| irq_o | output | IRQ_W | Per-channel lines, or one shared line |

## Verification
Two instances, one in each interrupt mode, receive the same stimulus. A reference model computes the expected values, and the interrupt outputs of both instances are compared against it after every edge. Seeded random traffic mixes the following:
- controller accesses to mapped and unmapped addresses
- random control bytes, so the enables switch on and off
- host strokes on all four ports

This random traffic reaches same-cycle collisions between the two sides. Directed sequences cover the cases that the random traffic hits only rarely:
- channel 3 with one of its two enable bits missing, which shows the two-bit enable apart from a single-bit one
- an enable dropped after the interrupt was raised, which shows an edge-triggered raise apart from a level one
- input-full cleared through the status register, which shows that only an input-data read lowers the line
- a controller read coinciding with a host write, which shows that set has priority over clear

// File: rtl/kcs_mbx_pkg.sv
package kcs_mbx_pkg;

  localparam int BYTE_W = 8;
  localparam int HCH_W  = 2;

  // status bit positions (host software decodes these)
  localparam int ST_OBF = 0;
  localparam int ST_IBF = 1;
  localparam int ST_CD  = 3;

  // control word addresses
  localparam int unsigned W_CTL0 = 0;
  localparam int unsigned W_CTL2 = 2;
  localparam int unsigned W_CTL4 = 4;
  localparam int unsigned W_CTLH = 64;

  typedef enum logic [1:0] {
    HP_DATA = 2'd0,
    HP_CMD  = 2'd1,
    HP_STAT = 2'd2,
    HP_NONE = 2'd3
  } hport_e;

  function automatic int unsigned idr_word(input int ch);
    return (ch < 3) ? 9 + ch : 69;
  endfunction

  function automatic int unsigned odr_word(input int ch);
    return (ch < 3) ? 12 + ch : 70;
  endfunction

  function automatic int unsigned str_word(input int ch);
    return (ch < 3) ? 15 + ch : 71;
  endfunction

endpackage

// File: rtl/kcs_mbx_ctl.sv
module kcs_mbx_ctl
  import kcs_mbx_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ctl0_q,
  output logic [BYTE_W-1:0] ctl2_q,
  output logic [BYTE_W-1:0] ctl4_q,
  output logic [BYTE_W-1:0] ctlh_q,
  output logic [NUM_CH-1:0] ch_en,
  output logic [NUM_CH-1:0] irq_en
);

  logic ld0, ld2, ld4, ldh;

  always_comb begin
    ld0 = wr && (addr == ADDR_W'(W_CTL0));
    ld2 = wr && (addr == ADDR_W'(W_CTL2));
    ld4 = wr && (addr == ADDR_W'(W_CTL4));
    ldh = wr && (addr == ADDR_W'(W_CTLH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl0_q <= '0;
      ctl2_q <= '0;
      ctl4_q <= '0;
      ctlh_q <= '0;
    end else begin
      if (ld0) ctl0_q <= wdata;
      if (ld2) ctl2_q <= wdata;
      if (ld4) ctl4_q <= wdata;
      if (ldh) ctlh_q <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_en
    if (g == 0) begin : g_c1
      assign ch_en[g] = ctl0_q[5];
      assign irq_en[g] = ctl0_q[5] & ctl2_q[1];
    end else if (g == 1) begin : g_c2
      assign ch_en[g] = ctl0_q[6];
      assign irq_en[g] = ctl0_q[6] & ctl2_q[2];
    end else if (g == 2) begin : g_c3
      // two independent bits must both be set
      assign ch_en[g] = ctl0_q[7] & ctl4_q[2];
      assign irq_en[g] = ctl0_q[7] & ctl4_q[2] & ctl2_q[3];
    end else begin : g_c4
      assign ch_en[g] = ctlh_q[0];
      assign irq_en[g] = ctlh_q[0] & ctlh_q[1];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
    AST_IE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en[g] |-> ch_en[g]) else $error("interrupt enable without channel enable"); // R8
  end

endmodule

// File: rtl/kcs_mbx_chan.sv
module kcs_mbx_chan
  import kcs_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_wr_idr,
  input  logic              c_wr_odr,
  input  logic              c_wr_str,
  input  logic              c_rd_idr,
  input  logic [BYTE_W-1:0] c_wdata,
  input  logic              h_wr_data,
  input  logic              h_wr_cmd,
  input  logic              h_rd_data,
  input  logic [BYTE_W-1:0] h_wdata,
  input  logic              irq_en,
  output logic [BYTE_W-1:0] idr_q,
  output logic [BYTE_W-1:0] odr_q,
  output logic [BYTE_W-1:0] str_q,
  output logic              ev_raise,
  output logic              ev_lower
);

  logic              h_wr_any;
  logic              ld_idr, ld_odr, ld_str;
  logic [BYTE_W-1:0] idr_d, odr_d, str_d;

  always_comb begin
    h_wr_any = h_wr_data | h_wr_cmd;
    ld_idr   = c_wr_idr | h_wr_any;
    ld_odr   = c_wr_odr;
    ld_str   = c_wr_str | c_rd_idr | h_rd_data | c_wr_odr | h_wr_any;

    idr_d = c_wr_idr ? c_wdata : idr_q;
    if (h_wr_any) idr_d = h_wdata;
    odr_d = c_wdata;

    // base value, then clears, then sets: a set beats a clear
    str_d = c_wr_str ? c_wdata : str_q;
    if (c_rd_idr)  str_d[ST_IBF] = 1'b0;
    if (h_rd_data) str_d[ST_OBF] = 1'b0;
    if (c_wr_odr)  str_d[ST_OBF] = 1'b1;
    if (h_wr_any) begin
      str_d[ST_IBF] = 1'b1;
      str_d[ST_CD]  = h_wr_cmd;
    end

    ev_raise = h_wr_any & irq_en;
    ev_lower = c_rd_idr & str_q[ST_IBF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr_q <= '0;
      odr_q <= '0;
      str_q <= '0;
    end else begin
      if (ld_idr) idr_q <= idr_d;
      if (ld_odr) odr_q <= odr_d;
      if (ld_str) str_q <= str_d;
    end
  end

  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_any |=> str_q[ST_IBF]) else $error("input full not set"); // R3
  AST_CD_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr_any |=> (str_q[ST_CD] == $past(h_wr_cmd))) else $error("command flag wrong"); // R3
  AST_IBF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (c_rd_idr && !h_wr_any) |=> !str_q[ST_IBF]) else $error("input full not cleared"); // R4
  AST_OBF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr_odr |=> str_q[ST_OBF]) else $error("output full not set"); // R5
  AST_OBF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd_data && !c_wr_odr) |=> !str_q[ST_OBF]) else $error("output full not cleared"); // R5
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr_any && c_wr_idr) |=> (idr_q == $past(h_wdata))) else $error("host write lost"); // R10

endmodule

// File: rtl/kcs_mbx_irq.sv
module kcs_mbx_irq #(
  parameter int NUM_CH     = 4,
  parameter bit SHARED_IRQ = 1'b0,
  localparam int IRQ_W     = SHARED_IRQ ? 1 : NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ev_raise,
  input  logic [NUM_CH-1:0] ev_lower,
  output logic [IRQ_W-1:0]  irq_o
);

  logic [NUM_CH-1:0] pend_q, pend_d;
  logic              pend_ld;

  always_comb begin
    pend_ld = |(ev_raise | ev_lower);
    pend_d  = pend_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ev_raise[i])      pend_d[i] = 1'b1;
      else if (ev_lower[i]) pend_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_ld) pend_q <= pend_d;
  end

  if (SHARED_IRQ) begin : g_shared
    assign irq_o = |pend_q;
    AST_SHARED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_o[0] && ev_raise == '0) |=> !irq_o[0]) else $error("shared line rose without event"); // R9
  end else begin : g_lines
    assign irq_o = pend_q;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ast
    AST_PEND_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      ev_raise[g] |=> pend_q[g]) else $error("pending bit not raised"); // R10
    AST_PEND_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_lower[g] && !ev_raise[g]) |=> !pend_q[g]) else $error("pending bit not lowered"); // R4
    AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_lower[g] && !ev_raise[g]) |=> $stable(pend_q[g])) else $error("pending bit moved"); // R12
  end

endmodule

// File: rtl/kcs_mbx.sv
module kcs_mbx
  import kcs_mbx_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int ADDR_W     = 7,
  parameter bit SHARED_IRQ = 1'b0,
  localparam int IRQ_W     = SHARED_IRQ ? 1 : NUM_CH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              c_wr,
  input  logic              c_rd,
  input  logic [ADDR_W-1:0] c_addr,
  input  logic [7:0]        c_wdata,
  output logic [7:0]        c_rdata,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [1:0]        h_chan,
  input  logic [1:0]        h_port,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  output logic [IRQ_W-1:0]  irq_o
);

  localparam int SV_W = NUM_CH * BYTE_W;

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [BYTE_W-1:0] ctl0, ctl2, ctl4, ctlh;
  logic [NUM_CH-1:0] ch_en, irq_en, ev_raise, ev_lower;
  logic [BYTE_W-1:0] idr_a [NUM_CH];
  logic [BYTE_W-1:0] odr_a [NUM_CH];
  logic [BYTE_W-1:0] str_a [NUM_CH];
  logic [SV_W-1:0]   state_v;
  hport_e            hp;
  logic              c_hit;

  assign hp = hport_e'(h_port);

  kcs_mbx_ctl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) ctl_i (
    .clk(clk), .rst_n(rst_sync_n), .wr(c_wr), .addr(c_addr), .wdata(c_wdata),
    .ctl0_q(ctl0), .ctl2_q(ctl2), .ctl4_q(ctl4), .ctlh_q(ctlh),
    .ch_en(ch_en), .irq_en(irq_en)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic sel_h;
    assign sel_h = (h_chan == HCH_W'(g));

    kcs_mbx_chan chan_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .c_wr_idr (c_wr && (c_addr == ADDR_W'(idr_word(g)))),
      .c_wr_odr (c_wr && (c_addr == ADDR_W'(odr_word(g)))),
      .c_wr_str (c_wr && (c_addr == ADDR_W'(str_word(g)))),
      .c_rd_idr (c_rd && (c_addr == ADDR_W'(idr_word(g)))),
      .c_wdata  (c_wdata),
      .h_wr_data(h_wr && sel_h && (hp == HP_DATA)),
      .h_wr_cmd (h_wr && sel_h && (hp == HP_CMD)),
      .h_rd_data(h_rd && sel_h && (hp == HP_DATA)),
      .h_wdata  (h_wdata),
      .irq_en   (irq_en[g]),
      .idr_q    (idr_a[g]),
      .odr_q    (odr_a[g]),
      .str_q    (str_a[g]),
      .ev_raise (ev_raise[g]),
      .ev_lower (ev_lower[g])
    );

    assign state_v[g*BYTE_W +: BYTE_W] = str_a[g] ^ idr_a[g] ^ odr_a[g];
  end

  kcs_mbx_irq #(.NUM_CH(NUM_CH), .SHARED_IRQ(SHARED_IRQ)) irq_i (
    .clk(clk), .rst_n(rst_sync_n), .ev_raise(ev_raise), .ev_lower(ev_lower), .irq_o(irq_o)
  );

  always_comb begin
    c_rdata = '0;
    c_hit   = 1'b0;
    if (c_addr == ADDR_W'(W_CTL0)) begin c_rdata = ctl0; c_hit = 1'b1; end
    if (c_addr == ADDR_W'(W_CTL2)) begin c_rdata = ctl2; c_hit = 1'b1; end
    if (c_addr == ADDR_W'(W_CTL4)) begin c_rdata = ctl4; c_hit = 1'b1; end
    if (c_addr == ADDR_W'(W_CTLH)) begin c_rdata = ctlh; c_hit = 1'b1; end
    for (int i = 0; i < NUM_CH; i++) begin
      if (c_addr == ADDR_W'(idr_word(i))) begin c_rdata = idr_a[i]; c_hit = 1'b1; end
      if (c_addr == ADDR_W'(odr_word(i))) begin c_rdata = odr_a[i]; c_hit = 1'b1; end
      if (c_addr == ADDR_W'(str_word(i))) begin c_rdata = str_a[i]; c_hit = 1'b1; end
    end
  end

  always_comb begin
    h_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (h_chan == HCH_W'(i)) begin
        case (hp)
          HP_DATA:         h_rdata = odr_a[i];
          HP_CMD, HP_STAT: h_rdata = str_a[i];
          default:         h_rdata = '0;
        endcase
      end
    end
  end

  AST_HOST_STAT_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (h_wr && !h_rd && hp == HP_STAT && !c_wr && !c_rd) |=> $stable(state_v))
    else $error("host status write changed state"); // R6
  AST_UNMAPPED_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (c_wr && !c_hit && !h_wr && !h_rd) |=> ($stable(state_v) && $stable(ctl0) && $stable(ctlh)))
    else $error("unmapped write changed state"); // R11
  AST_CH_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ev_raise & ~ch_en) == '0) else $error("raise on disabled channel"); // R7

endmodule

// File: tb/kcs_mbx_tb_top.sv
module kcs_mbx_tb_top;

  localparam int NCH = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       c_wr, c_rd, h_wr, h_rd;
  logic [6:0] c_addr;
  logic [7:0] c_wdata, h_wdata;
  logic [1:0] h_chan, h_port;
  logic [7:0] crd_i, crd_s, hrd_i, hrd_s;
  logic [3:0] irq_i;
  logic [0:0] irq_s;

  always #2 clk = ~clk;  // 250 MHz

  kcs_mbx #(.NUM_CH(NCH), .ADDR_W(7), .SHARED_IRQ(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(crd_i), .h_wr(h_wr), .h_rd(h_rd), .h_chan(h_chan), .h_port(h_port),
    .h_wdata(h_wdata), .h_rdata(hrd_i), .irq_o(irq_i));

  kcs_mbx #(.NUM_CH(NCH), .ADDR_W(7), .SHARED_IRQ(1'b1)) dut_shared_i (
    .clk(clk), .rst_n(rst_n), .c_wr(c_wr), .c_rd(c_rd), .c_addr(c_addr), .c_wdata(c_wdata),
    .c_rdata(crd_s), .h_wr(h_wr), .h_rd(h_rd), .h_chan(h_chan), .h_port(h_port),
    .h_wdata(h_wdata), .h_rdata(hrd_s), .irq_o(irq_s));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] m_ctl0, m_ctl2, m_ctl4, m_ctlh;
  logic [7:0] m_idr [NCH];
  logic [7:0] m_odr [NCH];
  logic [7:0] m_str [NCH];
  logic [3:0] m_pend;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // kind: 0 unmapped, 1 control, 2 input data, 3 output data, 4 status
  function automatic int akind(input logic [6:0] a);
    case (a)
      7'd0, 7'd2, 7'd4, 7'd64:     return 1;
      7'd9, 7'd10, 7'd11, 7'd69:   return 2;
      7'd12, 7'd13, 7'd14, 7'd70:  return 3;
      7'd15, 7'd16, 7'd17, 7'd71:  return 4;
      default:                     return 0;
    endcase
  endfunction

  function automatic int achan(input logic [6:0] a);
    case (a)
      7'd9, 7'd12, 7'd15:  return 0;
      7'd10, 7'd13, 7'd16: return 1;
      7'd11, 7'd14, 7'd17: return 2;
      default:             return 3;
    endcase
  endfunction

  function automatic string atag(input logic [6:0] a);
    case (akind(a))
      0:       return "R11";
      1:       return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [7:0] exp_crd(input logic [6:0] a);
    case (akind(a))
      1: return (a == 0) ? m_ctl0 : (a == 2) ? m_ctl2 : (a == 4) ? m_ctl4 : m_ctlh;
      2: return m_idr[achan(a)];
      3: return m_odr[achan(a)];
      4: return m_str[achan(a)];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_hrd(input logic [1:0] ch, input logic [1:0] p);
    if (p == 2'd0) return m_odr[ch];
    if (p == 2'd3) return 8'h00;
    return m_str[ch];
  endfunction

  function automatic bit m_arm(input int ch);
    case (ch)
      0:       return m_ctl0[5] & m_ctl2[1];
      1:       return m_ctl0[6] & m_ctl2[2];
      2:       return m_ctl0[7] & m_ctl4[2] & m_ctl2[3];
      default: return m_ctlh[0] & m_ctlh[1];
    endcase
  endfunction

  task automatic model_reset();
    m_ctl0 = 0; m_ctl2 = 0; m_ctl4 = 0; m_ctlh = 0; m_pend = 0;
    for (int i = 0; i < NCH; i++) begin m_idr[i] = 0; m_odr[i] = 0; m_str[i] = 0; end
  endtask

  task automatic model_step(input bit cw, input bit cr, input logic [6:0] ca, input logic [7:0] cd,
                            input bit hw, input bit hr, input logic [1:0] hc,
                            input logic [1:0] hp, input logic [7:0] hd);
    bit arm [NCH];
    for (int i = 0; i < NCH; i++) arm[i] = m_arm(i);
    for (int i = 0; i < NCH; i++) begin
      bit hwi, hrd, cwi, cwo, cws, cri, rise, low;
      logic [7:0] s;
      hwi = hw && hc == 2'(i) && (hp == 2'd0 || hp == 2'd1);
      hrd = hr && hc == 2'(i) && hp == 2'd0;
      cwi = cw && akind(ca) == 2 && achan(ca) == i;
      cwo = cw && akind(ca) == 3 && achan(ca) == i;
      cws = cw && akind(ca) == 4 && achan(ca) == i;
      cri = cr && akind(ca) == 2 && achan(ca) == i;
      rise = hwi && arm[i];
      low  = cri && m_str[i][1];
      if (cwi) m_idr[i] = cd;
      if (hwi) m_idr[i] = hd;
      if (cwo) m_odr[i] = cd;
      s = cws ? cd : m_str[i];
      if (cri) s[1] = 1'b0;
      if (hrd) s[0] = 1'b0;
      if (cwo) s[0] = 1'b1;
      if (hwi) begin s[1] = 1'b1; s[3] = (hp == 2'd1); end
      m_str[i] = s;
      if (rise) m_pend[i] = 1'b1;
      else if (low) m_pend[i] = 1'b0;
    end
    if (cw && ca == 7'd0)  m_ctl0 = cd;
    if (cw && ca == 7'd2)  m_ctl2 = cd;
    if (cw && ca == 7'd4)  m_ctl4 = cd;
    if (cw && ca == 7'd64) m_ctlh = cd;
  endtask

  task automatic step(input bit cw, input bit cr, input logic [6:0] ca, input logic [7:0] cd,
                      input bit hw, input bit hr, input logic [1:0] hc,
                      input logic [1:0] hp, input logic [7:0] hd);
    @(negedge clk);
    c_wr = cw; c_rd = cr; c_addr = ca; c_wdata = cd;
    h_wr = hw; h_rd = hr; h_chan = hc; h_port = hp; h_wdata = hd;
    #1;
    if (cr) begin
      chk(crd_i, exp_crd(ca), atag(ca));
      chk(crd_s, exp_crd(ca), atag(ca));
    end
    if (hr) begin
      chk(hrd_i, exp_hrd(hc, hp), (hp == 2'd0) ? "R5" : "R6");
      chk(hrd_s, exp_hrd(hc, hp), (hp == 2'd0) ? "R5" : "R6");
    end
    model_step(cw, cr, ca, cd, hw, hr, hc, hp, hd);
    @(posedge clk); #1;
    c_wr = 0; c_rd = 0; h_wr = 0; h_rd = 0;
    chk(irq_i, m_pend, "R9");
    chk(irq_s, |m_pend, "R9");
  endtask

  task automatic cwr(input logic [6:0] a, input logic [7:0] d); step(1, 0, a, d, 0, 0, 0, 0, 0); endtask
  task automatic crd(input logic [6:0] a); step(0, 1, a, 0, 0, 0, 0, 0, 0); endtask
  task automatic hwr(input logic [1:0] c, input logic [1:0] p, input logic [7:0] d); step(0, 0, 0, 0, 1, 0, c, p, d); endtask
  task automatic hrd(input logic [1:0] c, input logic [1:0] p); step(0, 0, 0, 0, 0, 1, c, p, 0); endtask

  function automatic logic [6:0] pick_addr();
    logic [6:0] lst [24] = '{7'd0, 7'd2, 7'd4, 7'd64, 7'd9, 7'd10, 7'd11, 7'd69,
                            7'd12, 7'd13, 7'd14, 7'd70, 7'd15, 7'd16, 7'd17, 7'd71,
                            7'd1, 7'd3, 7'd8, 7'd18, 7'd63, 7'd68, 7'd72, 7'd127};
    return lst[$urandom_range(0, 23)];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0C5));
    rst_n = 0; c_wr = 0; c_rd = 0; h_wr = 0; h_rd = 0;
    c_addr = 0; c_wdata = 0; h_chan = 0; h_port = 0; h_wdata = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: everything reads zero after reset
    foreach (m_idr[i]) begin
      chk(irq_i[i], 0, "R1");
    end
    chk(irq_s, 0, "R1");
    for (int a = 0; a < 72; a++) crd(7'(a));
    for (int c = 0; c < 4; c++) hrd(2'(c), 2'd1);

    // R7: channel 3 with only one of its two enable bits
    cwr(7'd0, 8'h80); cwr(7'd2, 8'h08); cwr(7'd4, 8'h00);
    hwr(2'd2, 2'd0, 8'hA5);
    chk(irq_i[2], 0, "R7");
    crd(7'd11);
    cwr(7'd4, 8'h04);
    hwr(2'd2, 2'd1, 8'h3C);
    chk(irq_i[2], 1, "R8");
    chk(irq_s, 1, "R9");
    // R3: command write sets bit 3 and bit 1
    crd(7'd17);
    chk(crd_i, 8'h0A, "R3");
    // R8: dropping the enable later leaves the line up
    cwr(7'd2, 8'h00);
    chk(irq_i[2], 1, "R8");
    crd(7'd11);
    chk(irq_i[2], 0, "R4");

    // R12: clearing input-full through status keeps pending
    cwr(7'd0, 8'h20); cwr(7'd2, 8'h02);
    hwr(2'd0, 2'd0, 8'h11);
    cwr(7'd15, 8'h00);
    chk(irq_i[0], 1, "R12");
    crd(7'd9);
    chk(irq_i[0], 1, "R12");
    hwr(2'd0, 2'd0, 8'h12);
    crd(7'd9);
    chk(irq_i[0], 0, "R4");

    // R10: controller read of input data coinciding with a host write
    hwr(2'd0, 2'd0, 8'h21);
    step(0, 1, 7'd9, 0, 1, 0, 2'd0, 2'd1, 8'h22);
    chk(irq_i[0], 1, "R10");
    crd(7'd15);
    chk(crd_i, 8'h0A, "R10");
    // R10: controller and host write same input register
    step(1, 0, 7'd9, 8'h99, 1, 0, 2'd0, 2'd0, 8'h77);
    crd(7'd9);
    chk(crd_i, 8'h77, "R10");
    // R10: output full set and cleared together
    step(1, 0, 7'd12, 8'h44, 0, 1, 2'd0, 2'd0, 0);
    crd(7'd15);
    chk(crd_i[0], 1, "R10");

    // R5: host read of output empties it; channel 4 bank
    cwr(7'd64, 8'h03);
    cwr(7'd70, 8'h5A);
    hrd(2'd3, 2'd0);
    chk(hrd_i, 8'h5A, "R5");
    crd(7'd71);
    chk(crd_i, 8'h00, "R5");
    hwr(2'd3, 2'd0, 8'h66);
    chk(irq_i[3], 1, "R8");
    crd(7'd69);
    chk(irq_i[3], 0, "R4");

    // R6 and R11: ignored writes
    hwr(2'd1, 2'd2, 8'hFF);
    crd(7'd16);
    chk(crd_i, 8'h00, "R6");
    hwr(2'd1, 2'd3, 8'hFF);
    crd(7'd10);
    chk(crd_i, 8'h00, "R11");
    cwr(7'd1, 8'hFF);
    crd(7'd1);
    chk(crd_i, 8'h00, "R11");

    // seeded random traffic in both modes
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 2);
      int ho = $urandom_range(0, 2);
      step(op == 1, op == 2, pick_addr(), 8'($urandom),
           ho == 1, ho == 2, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 8'($urandom));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule